// File: doc/BRIEF.md
# Ten-Bit Word Serializer with Internal Wrap Path

This block turns 10-bit parallel transmit words into a serial bit stream. It runs entirely in one fast bit-clock domain. A single-cycle word strobe, which occurs at most once every ten bit-clock cycles, stands in for the slow word clock and marks the cycle on which a new word is presented. Each strobed word first lands in a holding register. A separate shift register then drains it one bit per cycle, least significant bit first. The shift register refills from the holding register straight after its last bit, so words strobed at the full one-in-ten rate leave as one stream with no gaps.

A wrap control selects where the stream goes. In normal operation it drives the line output, and the loopback output rests high. In wrap mode the same stream is steered to the loopback output, which feeds the receive path for diagnostics, and the line output is held at a constant one. A rate-select input, active low, records whether the link runs at full or half line rate. It drives a registered status output only and never changes the serial timing.

Top module: `tx_word_serializer`

## Requirements
- R1: While synchronous reset `rst` is high, and on the first cycle after it is released, `line_out` and `loop_out` are 1. No data bit appears before the first strobe.
- R2: A word on `word_in` is captured on a clock edge where `word_stb` is 1. If the shift register is empty, the word's bit 0 is on the serial stream in the cycle that follows the next edge.
- R3: A word leaves as ten consecutive serial bits, bit 0 first and bit 9 last.
- R4: Words strobed every ten cycles produce a gapless stream: the next word's bit 0 follows the previous word's bit 9 in the very next cycle.
- R5: When no word is being shifted, the serial stream is 1.
- R6: A strobe that arrives while the holding register still contains a word that has not yet been loaded replaces that word. The replaced word is never sent, and the word already shifting is not disturbed.
- R7: A strobe on the same edge as the shift register loads from the holding register is handled without loss. The loaded word is the old one, and the new word is sent next.
- R8: With `wrap_en` = 1, `line_out` is 1 and `loop_out` carries the serial stream.
- R9: With `wrap_en` = 0, `line_out` carries the serial stream and `loop_out` is 1.
- R10: `half_rate` is 0 after reset. After each edge it equals the value `rate_sel_n` had at that edge (0 = full rate, 1 = half rate). The rate select has no effect on the serial stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| word_stb | input | 1 | One-cycle strobe marking a new word |
| word_in | input | 10 | Parallel transmit word, bit 0 sent first |
| wrap_en | input | 1 | 1 routes the stream to the loopback output |
| rate_sel_n | input | 1 | Rate select, 0 full rate, 1 half rate |
| line_out | output | 1 | Serial line output, 1 when idle or in wrap |
| loop_out | output | 1 | Internal loopback serial output, 1 unless wrap |
| half_rate | output | 1 | Registered rate status |

## Verification
The case that needs care is a strobe landing on the same edge as the shift register pulls from the holding register. On that edge the holding register must hand over its old word and take the new one at once. The bench provokes this by strobing one cycle after a strobe into an idle shifter, and by strobing again while a word is still waiting. It then deserializes the outputs against a bench model built only from the start rule "one cycle after the strobe or right after the previous word, whichever is later". A lost, duplicated or reordered word shows up as a bit mismatch at a known cycle.

// File: rtl/txser_pkg.sv
package txser_pkg;
   localparam int unsigned TXSER_WORD_W = 10;
   localparam logic        TXSER_IDLE   = 1'b1;
endpackage

// File: rtl/txser_hold.sv
module txser_hold #(
   parameter int unsigned WORD_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              word_stb,
   input  logic [WORD_W-1:0] word_in,
   input  logic              take,
   output logic              hold_vld,
   output logic [WORD_W-1:0] hold_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         hold_vld <= 1'b0;
         hold_q   <= '0;
      end else begin
         if (word_stb) begin
            hold_vld <= 1'b1;
            hold_q   <= word_in;
         end else if (take) begin
            hold_vld <= 1'b0;
         end
      end
   end

   // R2: a strobed word is held on the following cycle
   p_capture_r2: assert property (@(posedge clk) disable iff (rst)
      word_stb |=> (hold_vld && hold_q == $past(word_in)));

   // R6: once taken with no new strobe, the holding register is empty
   p_take_clears_r6: assert property (@(posedge clk) disable iff (rst)
      (take && !word_stb) |=> !hold_vld);
endmodule

// File: rtl/txser_shift.sv
module txser_shift
   import txser_pkg::*;
#(
   parameter int unsigned WORD_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hold_vld,
   input  logic [WORD_W-1:0] hold_q,
   output logic              take,
   output logic              ser_bit
);
   localparam int unsigned CNT_W = $clog2(WORD_W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic [WORD_W-1:0] sh_q;
   logic [CNT_W-1:0]  left_q;

   assign take    = hold_vld && (left_q <= CNT_ONE);
   assign ser_bit = (left_q != '0) ? sh_q[0] : TXSER_IDLE;

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q   <= '0;
         left_q <= '0;
      end else if (take) begin
         sh_q   <= hold_q;
         left_q <= CNT_FULL;
      end else if (left_q != '0) begin
         sh_q   <= sh_q >> 1;
         left_q <= left_q - CNT_ONE;
      end
   end

   // R4: the last bit is followed at once by a full reload when a word waits
   p_reload_gapless_r4: assert property (@(posedge clk) disable iff (rst)
      (left_q == CNT_ONE && hold_vld) |=> (left_q == CNT_FULL));

   // R3: mid-word, the next bit out is the one above the current bit
   p_lsb_first_r3: assert property (@(posedge clk) disable iff (rst)
      (left_q > CNT_ONE && !hold_vld) |=> (ser_bit == $past(sh_q[1])));

   // R5: without a waiting word, an emptied shifter stays idle
   p_stays_idle_r5: assert property (@(posedge clk) disable iff (rst)
      (left_q == '0 && !hold_vld) |=> (left_q == '0));
endmodule

// File: rtl/txser_route.sv
module txser_route
   import txser_pkg::*;
(
   input  logic ser_bit,
   input  logic wrap_en,
   output logic line_out,
   output logic loop_out
);
   always_comb begin
      if (wrap_en) begin
         line_out = TXSER_IDLE;
         loop_out = ser_bit;
      end else begin
         line_out = ser_bit;
         loop_out = TXSER_IDLE;
      end
   end
endmodule

// File: rtl/tx_word_serializer.sv
module tx_word_serializer
   import txser_pkg::*;
#(
   parameter int unsigned WORD_W = TXSER_WORD_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              word_stb,
   input  logic [WORD_W-1:0] word_in,
   input  logic              wrap_en,
   input  logic              rate_sel_n,
   output logic              line_out,
   output logic              loop_out,
   output logic              half_rate
);
   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("tx_word_serializer: WORD_W must be at least 2");
      end
   endgenerate

   logic              take;
   logic              hold_vld;
   logic [WORD_W-1:0] hold_q;
   logic              ser_bit;

   txser_hold #(.WORD_W(WORD_W)) u_hold (
      .clk      (clk),
      .rst      (rst),
      .word_stb (word_stb),
      .word_in  (word_in),
      .take     (take),
      .hold_vld (hold_vld),
      .hold_q   (hold_q)
   );

   txser_shift #(.WORD_W(WORD_W)) u_shift (
      .clk      (clk),
      .rst      (rst),
      .hold_vld (hold_vld),
      .hold_q   (hold_q),
      .take     (take),
      .ser_bit  (ser_bit)
   );

   txser_route u_route (
      .ser_bit  (ser_bit),
      .wrap_en  (wrap_en),
      .line_out (line_out),
      .loop_out (loop_out)
   );

   always_ff @(posedge clk) begin
      if (rst) half_rate <= 1'b0;
      else     half_rate <= rate_sel_n;
   end

   // R10: the status follows the rate select one edge later
   p_rate_track_r10: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (half_rate == $past(rate_sel_n)));

   // R8: a wrapped, active stream never reaches the line
   p_wrap_line_high_r8: assert property (@(posedge clk) disable iff (rst)
      (wrap_en && !ser_bit) |-> (line_out && !loop_out));
endmodule

// File: tb/tb_tx_word_serializer.sv
module tb_tx_word_serializer;
   localparam int EXP_N = 4096;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       word_stb = 1'b0;
   logic [9:0] word_in = '0;
   logic       wrap_en = 1'b0;
   logic       rate_sel_n = 1'b0;
   logic       line_out, loop_out, half_rate;

   int  n_chk = 0;
   int  n_fail = 0;
   int  n = 0;
   bit  expv [0:EXP_N-1];
   int  last_end = 0;
   int  pend_start = 0;
   bit  pend_v = 1'b0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   tx_word_serializer dut (
      .clk(clk), .rst(rst), .word_stb(word_stb), .word_in(word_in),
      .wrap_en(wrap_en), .rate_sel_n(rate_sel_n),
      .line_out(line_out), .loop_out(loop_out), .half_rate(half_rate)
   );

   task automatic chk(input bit ok, input string req, input logic act, input logic exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s edge %0d: actual %0b expected %0b", req, n, act, exp);
      end
   endtask

   // expected stream: start = later of (strobe edge + 1) and end of previous word
   task automatic model_push(input int s, input logic [9:0] w);
      int base, start;
      if (pend_v && pend_start > s) begin
         for (int i = 0; i < 10; i++) expv[pend_start + i] = 1'b1;
         base = last_end;
      end else begin
         if (pend_v) last_end = pend_start + 10;
         base = last_end;
      end
      start = (s + 1 > base) ? s + 1 : base;
      for (int i = 0; i < 10; i++) expv[start + i] = w[i];
      pend_start = start;
      pend_v = 1'b1;
   endtask

   task automatic check_outputs(input logic rate_at_edge);
      logic e;
      e = expv[n];
      if (wrap_en) begin
         chk(line_out == 1'b1, "R8 line", line_out, 1'b1);
         chk(loop_out == e, "R8/R3 loop stream", loop_out, e);
      end else begin
         chk(line_out == e, "R3/R4 line stream", line_out, e);
         chk(loop_out == 1'b1, "R9 loop idle", loop_out, 1'b1);
      end
      chk(half_rate == rate_at_edge, "R10 rate status", half_rate, rate_at_edge);
   endtask

   task automatic tick(input bit stb, input logic [9:0] w);
      logic r;
      word_stb = stb;
      word_in  = w;
      r = rate_sel_n;
      if (stb) model_push(n + 1, w);
      @(negedge clk);
      n++;
      word_stb = 1'b0;
      check_outputs(r);
   endtask

   task automatic idle(input int k);
      for (int i = 0; i < k; i++) tick(1'b0, '0);
   endtask

   initial begin
      for (int i = 0; i < EXP_N; i++) expv[i] = 1'b1;
      void'($urandom(32'h5EED_0A17));
      repeat (3) @(negedge clk);
      // R1: outputs high during reset
      chk(line_out == 1'b1, "R1 line in reset", line_out, 1'b1);
      chk(loop_out == 1'b1, "R1 loop in reset", loop_out, 1'b1);
      chk(half_rate == 1'b0, "R1/R10 status in reset", half_rate, 1'b0);
      rst = 1'b0;
      // R1, R5: nothing appears without a strobe
      idle(6);

      // R2, R3: single word into an idle shifter, bit 0 one cycle after the strobe edge
      tick(1'b1, 10'b10_1100_1101);
      idle(14);

      // R4: back-to-back words at the full rate
      for (int k = 0; k < 40; k++) begin
         tick(1'b1, 10'($urandom));
         idle(9);
      end
      idle(5);

      // R5, R10: random spacing with idle gaps, rate select toggling
      for (int k = 0; k < 50; k++) begin
         rate_sel_n = 1'($urandom);
         tick(1'b1, 10'($urandom));
         idle(9 + int'($urandom % 5));
      end
      rate_sel_n = 1'b0;
      idle(12);

      // R7: second strobe on the edge where the first word is loaded
      tick(1'b1, 10'h2A5);
      tick(1'b1, 10'h15A);
      idle(25);

      // R6: a waiting word replaced before it is loaded
      tick(1'b1, 10'h3F0);
      idle(2);
      tick(1'b1, 10'h001);
      idle(1);
      tick(1'b1, 10'h2CC);
      idle(25);

      // R8: wrap mode with streaming, then R9 back to normal while words move
      wrap_en = 1'b1;
      for (int k = 0; k < 20; k++) begin
         tick(1'b1, 10'($urandom));
         idle(9);
      end
      for (int k = 0; k < 20; k++) begin
         tick(1'b1, 10'($urandom));
         idle(3);
         wrap_en = 1'($urandom);
         idle(6);
      end
      wrap_en = 1'b0;
      idle(15);

      // R10: rate status is held high, stream unaffected
      rate_sel_n = 1'b1;
      tick(1'b1, 10'h3FF);
      tick(1'b0, '0);
      tick(1'b0, '0);
      idle(12);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule